// File: doc/BRIEF.md
# Bridge error event masking monitor

This block watches the upstream side of a bus bridge for error conditions that warrant a system-error report. It keeps three independent retry counters, one each for outstanding delayed reads, delayed writes and posted writes. A transaction that is retried up to the limit without finishing raises a timeout event. Posted writes can also fail in three other ways: a master abort, a target abort, or a data parity error. Each of these is a separate event class.

An 8-bit mask register, reached through a small configuration read/write port, picks which event classes may raise the one-cycle system-error request. Every event, masked or not, sets its own sticky status bit. Software reads the status bits through the same port and clears them by writing 1. Bus signalling, transaction queuing and the open-drain error pin lie outside the block.

Top module: `bridge_err_mask_mon`

## Requirements
- R1: After reset the mask register (config offset 0x64) reads 0x00, the status register (config offset 0x65) reads 0x00 and `serr_req` is low, so every event class is reported.
- R2: Mask bits 7 and 0 are reserved. They always read 0, and writing 1 to them has no effect on the value read back.
- R3: Mask bits 6..1 are read/write. A written value reads back unchanged on those bits, and a 1 suppresses the event class that bit stands for.
- R4: A delayed read retried 2^RETRY_W times without completing raises the delayed-read timeout event. This event is status/mask bit 6. The pulse follows the 2^RETRY_W-th retry.
- R5: The delayed-write timeout uses the same retry limit and is status/mask bit 5.
- R6: The posted-write timeout uses the same retry limit and is status/mask bit 2.
- R7: A posted-write master abort is status/mask bit 4. A posted-write target abort is status/mask bit 3.
- R8: A posted-write data parity error is status/mask bit 1.
- R9: A retry counter returns to zero when its transaction completes. The posted-write counter also returns to zero on a master or target abort. After that, a full 2^RETRY_W retries are needed again. A retry in the same cycle as a completion causes no timeout.
- R10: A transaction raises at most one timeout event, however many retries follow the limit.
- R11: `serr_req` is high for exactly one cycle, one cycle after each cycle that holds at least one unmasked event. Events that arrive together give one pulse and set all their status bits.
- R12: A masked event sets its status bit but gives no `serr_req` pulse.
- R13: Writing 1 to a status bit at offset 0x65 clears it, and writing 0 leaves it alone. A new event in the same cycle as the clear keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | CFG_AW | Configuration address (read and write) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| dr_retry | input | 1 | Delayed read was retried this cycle |
| dr_done | input | 1 | Delayed read completed or aborted |
| dw_retry | input | 1 | Delayed write was retried this cycle |
| dw_done | input | 1 | Delayed write completed or aborted |
| pw_retry | input | 1 | Posted write was retried this cycle |
| pw_done | input | 1 | Posted write completed |
| pw_mabort | input | 1 | Posted write ended in master abort |
| pw_tabort | input | 1 | Posted write ended in target abort |
| pw_perr | input | 1 | Parity error on posted write data |
| serr_req | output | 1 | One-cycle system-error request |
| err_status | output | 8 | Sticky event status, same bit map as the mask |

## Verification
Every event result, meaning the `serr_req` pulse and the sticky status bit, is due at the first rising edge after the edge that samples the event inputs. A mask or status write takes effect at its own edge. The bench drives every input on the falling edge and holds it for one full cycle. It then samples `serr_req` and `err_status` on the next falling edge, which lies exactly one register stage after the sampling edge. The falling edge after that confirms the pulse has dropped again. The read path is combinational, so configuration reads are sampled one time unit after the address changes.

// File: rtl/errmon_pkg.sv
package errmon_pkg;

   localparam int unsigned REG_W = 8;

   // Event positions inside the mask and status registers
   localparam int unsigned EVB_PW_PERR = 1;
   localparam int unsigned EVB_PW_TMO  = 2;
   localparam int unsigned EVB_PW_TABT = 3;
   localparam int unsigned EVB_PW_MABT = 4;
   localparam int unsigned EVB_DW_TMO  = 5;
   localparam int unsigned EVB_DR_TMO  = 6;

   // Bits that hold state; 7 and 0 are reserved zero
   localparam logic [REG_W-1:0] LIVE_BITS = 8'h7E;

   localparam int unsigned N_XFER = 3;

   typedef enum logic [1:0] {
      XFER_DR = 2'd0,
      XFER_DW = 2'd1,
      XFER_PW = 2'd2
   } xfer_e;

   function automatic int unsigned tmo_bit(input int unsigned k);
      case (k)
         0:       return EVB_DR_TMO;
         1:       return EVB_DW_TMO;
         default: return EVB_PW_TMO;
      endcase
   endfunction

endpackage

// File: rtl/errmon_retry_timer.sv
module errmon_retry_timer #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retry,
   input  logic             clear,
   output logic             timeout,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] cnt_q;
   logic             fired_q;
   logic             at_max;

   assign at_max  = &cnt_q;
   // Limit-th retry fires once; a completing transaction never fires
   assign timeout = retry & ~clear & ~fired_q & at_max;
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (clear) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (retry && !fired_q) begin
         if (at_max) fired_q <= 1'b1;
         else        cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/errmon_cfg_reg.sv
module errmon_cfg_reg #(
   parameter int unsigned AW    = 8,
   parameter int unsigned OFS   = 'h64,
   parameter logic [7:0]  WMASK = 8'h7E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [7:0]    wdata,
   output logic [7:0]    q
);

   localparam logic [AW-1:0] SEL_ADDR = AW'(OFS);

   logic hit;
   assign hit = wr && (addr == SEL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata & WMASK;
   end

endmodule

// File: rtl/errmon_status.sv
module errmon_status #(
   parameter int unsigned AW    = 8,
   parameter int unsigned OFS   = 'h65,
   parameter logic [7:0]  LIVE  = 8'h7E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    evt,
   input  logic [7:0]    mask,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [7:0]    wdata,
   output logic [7:0]    sticky,
   output logic          req
);

   localparam logic [AW-1:0] SEL_ADDR = AW'(OFS);

   logic [7:0] clr_bits;
   logic [7:0] st_next;
   logic       any_live;

   always_comb begin
      clr_bits = (wr && (addr == SEL_ADDR)) ? wdata : 8'h00;
      // A new event outranks a clear in the same cycle
      st_next  = ((sticky & ~clr_bits) | evt) & LIVE;
      any_live = |(evt & ~mask & LIVE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         req    <= 1'b0;
      end else begin
         sticky <= st_next;
         req    <= any_live;
      end
   end

endmodule

// File: rtl/bridge_err_mask_mon.sv
module bridge_err_mask_mon
   import errmon_pkg::*;
#(
   parameter int unsigned RETRY_W   = 24,
   parameter int unsigned CFG_AW    = 8,
   parameter int unsigned MASK_OFS  = 'h64,
   parameter int unsigned STAT_OFS  = 'h65,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              dr_retry,
   input  logic              dr_done,
   input  logic              dw_retry,
   input  logic              dw_done,
   input  logic              pw_retry,
   input  logic              pw_done,
   input  logic              pw_mabort,
   input  logic              pw_tabort,
   input  logic              pw_perr,
   output logic              serr_req,
   output logic [7:0]        err_status
);

   localparam int unsigned    CNT_FLAT_W = N_XFER * RETRY_W;
   localparam logic [CFG_AW-1:0] MASK_A = CFG_AW'(MASK_OFS);
   localparam logic [CFG_AW-1:0] STAT_A = CFG_AW'(STAT_OFS);

   // Elaboration checks
   if (RETRY_W < 2 || RETRY_W > 32) begin : g_bad_retry_w
      $error("RETRY_W must lie in 2..32");
   end
   if (CFG_AW < 7 || CFG_AW > 16) begin : g_bad_cfg_aw
      $error("CFG_AW must lie in 7..16");
   end
   if (MASK_OFS == STAT_OFS) begin : g_bad_ofs
      $error("MASK_OFS and STAT_OFS must differ");
   end
   if (MASK_OFS >= (1 << CFG_AW) || STAT_OFS >= (1 << CFG_AW)) begin : g_bad_range
      $error("offsets exceed the CFG_AW address range");
   end

   logic [N_XFER-1:0]     retry_v;
   logic [N_XFER-1:0]     clear_v;
   logic [N_XFER-1:0]     tmo_v;
   logic [CNT_FLAT_W-1:0] cnt_flat;
   logic [7:0]            mask_q;
   logic [7:0]            evt_v;
   logic [7:0]            rd_next;

   assign retry_v[XFER_DR] = dr_retry;
   assign retry_v[XFER_DW] = dw_retry;
   assign retry_v[XFER_PW] = pw_retry;
   assign clear_v[XFER_DR] = dr_done;
   assign clear_v[XFER_DW] = dw_done;
   assign clear_v[XFER_PW] = pw_done | pw_mabort | pw_tabort;

   for (genvar k = 0; k < N_XFER; k++) begin : g_timer
      errmon_retry_timer #(.CNT_W(RETRY_W)) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .retry   (retry_v[k]),
         .clear   (clear_v[k]),
         .timeout (tmo_v[k]),
         .count   (cnt_flat[k*RETRY_W +: RETRY_W])
      );
   end

   always_comb begin
      evt_v = '0;
      for (int k = 0; k < N_XFER; k++) begin
         evt_v[tmo_bit(k)] = tmo_v[k];
      end
      evt_v[EVB_PW_MABT] = pw_mabort;
      evt_v[EVB_PW_TABT] = pw_tabort;
      evt_v[EVB_PW_PERR] = pw_perr;
   end

   errmon_cfg_reg #(
      .AW(CFG_AW), .OFS(MASK_OFS), .WMASK(LIVE_BITS)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (cfg_addr),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .q     (mask_q)
   );

   errmon_status #(
      .AW(CFG_AW), .OFS(STAT_OFS), .LIVE(LIVE_BITS)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_v),
      .mask   (mask_q),
      .addr   (cfg_addr),
      .wr     (cfg_wr),
      .wdata  (cfg_wdata),
      .sticky (err_status),
      .req    (serr_req)
   );

   always_comb begin
      if      (cfg_addr == MASK_A) rd_next = mask_q;
      else if (cfg_addr == STAT_A) rd_next = err_status;
      else                         rd_next = 8'h00;
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [7:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_next;
      end
      assign cfg_rdata = rd_q;
   end else begin : g_rd_comb
      assign cfg_rdata = rd_next;
   end

endmodule

// File: rtl/errmon_chk.sv
module errmon_chk #(
   parameter int unsigned RETRY_W  = 24,
   parameter int unsigned CFG_AW   = 8,
   parameter int unsigned MASK_OFS = 'h64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [CFG_AW-1:0]      cfg_addr,
   input logic                   cfg_wr,
   input logic [7:0]             cfg_wdata,
   input logic [7:0]             mask,
   input logic [7:0]             evt,
   input logic [7:0]             status,
   input logic                   serr,
   input logic [2:0]             tmo,
   input logic [2:0]             clr,
   input logic [3*RETRY_W-1:0]   cnt_flat
);

   localparam logic [CFG_AW-1:0] MASK_A = CFG_AW'(MASK_OFS);

   // R1: reset leaves everything clear
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (mask == 8'h00 && status == 8'h00 && !serr));

   // R3 (with R2): only the live bits take the written value
   p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == MASK_A) |=> (mask == ($past(cfg_wdata) & 8'h7E)));

   // R11: a pulse always has an unmasked event behind it
   p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      serr |-> $past(|(evt & ~mask & 8'h7E)));

   // R12: no unmasked event, no pulse
   p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & ~mask & 8'h7E) == 8'h00) |=> !serr);

   // R11: every event lands in status
   p_status_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 8'h00) |=> ((status & $past(evt)) == $past(evt)));

   for (genvar k = 0; k < 3; k++) begin : g_tmr_chk
      // R4: a timeout only at a full counter
      p_tmo_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
         tmo[k] |-> (cnt_flat[k*RETRY_W +: RETRY_W] == {RETRY_W{1'b1}}));
      // R10: a timeout never repeats back to back
      p_tmo_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
         tmo[k] |=> !tmo[k]);
      // R9: completion or abort empties the counter
      p_clear_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
         clr[k] |=> (cnt_flat[k*RETRY_W +: RETRY_W] == '0));
   end

endmodule

bind bridge_err_mask_mon errmon_chk #(
   .RETRY_W(RETRY_W), .CFG_AW(CFG_AW), .MASK_OFS(MASK_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .mask      (mask_q),
   .evt       (evt_v),
   .status    (err_status),
   .serr      (serr_req),
   .tmo       (tmo_v),
   .clr       (clear_v),
   .cnt_flat  (cnt_flat)
);

// File: tb/bridge_err_mask_mon_bench.sv
module bridge_err_mask_mon_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TB_RETRY_W = 3;
   localparam int LIMIT      = 1 << TB_RETRY_W;
   localparam logic [7:0] A_MASK = 8'h64;
   localparam logic [7:0] A_STAT = 8'h65;

   // stimulus vector positions
   localparam int S_DR_RETRY = 0;
   localparam int S_DR_DONE  = 1;
   localparam int S_DW_RETRY = 2;
   localparam int S_DW_DONE  = 3;
   localparam int S_PW_RETRY = 4;
   localparam int S_PW_DONE  = 5;
   localparam int S_MABT     = 6;
   localparam int S_TABT     = 7;
   localparam int S_PERR     = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic [8:0] stim = '0;
   logic       serr_req;
   logic [7:0] err_status;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bridge_err_mask_mon #(.RETRY_W(TB_RETRY_W)) u_bridge_err_mask_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_addr   (cfg_addr),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .dr_retry   (stim[S_DR_RETRY]),
      .dr_done    (stim[S_DR_DONE]),
      .dw_retry   (stim[S_DW_RETRY]),
      .dw_done    (stim[S_DW_DONE]),
      .pw_retry   (stim[S_PW_RETRY]),
      .pw_done    (stim[S_PW_DONE]),
      .pw_mabort  (stim[S_MABT]),
      .pw_tabort  (stim[S_TABT]),
      .pw_perr    (stim[S_PERR]),
      .serr_req   (serr_req),
      .err_status (err_status)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   // one-cycle stimulus; results sampled one edge later
   task automatic apply(input logic [8:0] s, output logic p, output logic [7:0] st);
      @(negedge clk);
      stim = s;
      @(negedge clk);
      stim = '0;
      p  = serr_req;
      st = err_status;
   endtask

   task automatic retries(input int idx, input int n, output int pulses, output logic [7:0] st);
      logic p;
      pulses = 0;
      st = 8'h00;
      for (int i = 0; i < n; i++) begin
         apply(9'(1) << idx, p, st);
         if (p) pulses++;
      end
   endtask

   task automatic clear_all();
      cfg_write(A_STAT, 8'hFF);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      cfg_read(A_MASK, d);  chk("R1 mask after reset", d, 8'h00);
      cfg_read(A_STAT, d);  chk("R1 status after reset", d, 8'h00);
      chk("R1 serr_req after reset", serr_req, 0);
   endtask

   task automatic t_mask_rw();
      logic [7:0] d;
      cfg_write(A_MASK, 8'hFF); cfg_read(A_MASK, d);
      chk("R3 all-ones write reads live bits", d, 8'h7E);
      cfg_write(A_MASK, 8'h81); cfg_read(A_MASK, d);
      chk("R2 reserved bits ignore writes", d, 8'h00);
      cfg_write(A_MASK, 8'h2A); cfg_read(A_MASK, d);
      chk("R3 pattern read back", d, 8'h2A);
      cfg_write(A_MASK, 8'h00);
   endtask

   task automatic t_dr_timeout();
      int n; logic p; logic [7:0] st;
      retries(S_DR_RETRY, LIMIT-1, n, st);
      chk("R4 no event below limit", n, 0);
      chk("R4 no status below limit", st, 8'h00);
      apply(9'(1) << S_DR_RETRY, p, st);
      chk("R4 pulse on limit retry", p, 1);
      chk("R4 status bit 6", st, 8'h40);
      apply('0, p, st);
      chk("R11 pulse lasts one cycle", p, 0);
      retries(S_DR_RETRY, LIMIT+2, n, st);
      chk("R10 no second timeout", n, 0);
      apply(9'(1) << S_DR_DONE, p, st);
      clear_all();
      chk("R13 W1C clears status", err_status, 8'h00);
   endtask

   task automatic t_dw_timeout();
      int n; logic p; logic [7:0] st;
      cfg_write(A_MASK, 8'h20);
      retries(S_DW_RETRY, LIMIT, n, st);
      chk("R12 masked timeout gives no pulse", n, 0);
      chk("R5 R12 masked timeout sets bit 5", st, 8'h20);
      cfg_write(A_MASK, 8'h00);
      apply(9'(1) << S_DW_DONE, p, st);
      clear_all();
      retries(S_DW_RETRY, LIMIT, n, st);
      chk("R5 unmasked delayed-write timeout pulses", n, 1);
      chk("R5 status bit 5", st, 8'h20);
      apply(9'(1) << S_DW_DONE, p, st);
      clear_all();
   endtask

   task automatic t_pw_timeout();
      int n; logic p; logic [7:0] st;
      retries(S_PW_RETRY, LIMIT, n, st);
      chk("R6 posted-write timeout pulses", n, 1);
      chk("R6 status bit 2", st, 8'h04);
      apply(9'(1) << S_PW_DONE, p, st);
      clear_all();
   endtask

   task automatic t_restart();
      int n; int n2; logic p; logic [7:0] st;
      retries(S_DR_RETRY, LIMIT-3, n, st);
      apply((9'(1) << S_DR_RETRY) | (9'(1) << S_DR_DONE), p, st);
      chk("R9 retry with completion gives no event", p, 0);
      retries(S_DR_RETRY, LIMIT-1, n, st);
      chk("R9 counter restarted after completion", n, 0);
      retries(S_DR_RETRY, 1, n2, st);
      chk("R9 full limit after restart", n2, 1);
      apply(9'(1) << S_DR_DONE, p, st);
      clear_all();
      // abort also restarts the posted-write counter
      retries(S_PW_RETRY, LIMIT-2, n, st);
      apply(9'(1) << S_MABT, p, st);
      retries(S_PW_RETRY, LIMIT-1, n, st);
      chk("R9 abort restarts posted-write counter", n, 0);
      chk("R9 only abort status present", st, 8'h10);
      apply(9'(1) << S_PW_DONE, p, st);
      clear_all();
   endtask

   task automatic t_aborts();
      logic p; logic [7:0] st;
      apply(9'(1) << S_MABT, p, st);
      chk("R7 master abort pulses", p, 1);
      chk("R7 master abort bit 4", st, 8'h10);
      clear_all();
      apply(9'(1) << S_TABT, p, st);
      chk("R7 target abort pulses", p, 1);
      chk("R7 target abort bit 3", st, 8'h08);
      clear_all();
      cfg_write(A_MASK, 8'h10);
      apply(9'(1) << S_MABT, p, st);
      chk("R12 masked master abort no pulse", p, 0);
      chk("R12 masked master abort status", st, 8'h10);
      cfg_write(A_MASK, 8'h00);
      clear_all();
   endtask

   task automatic t_parity();
      logic p; logic [7:0] st;
      apply(9'(1) << S_PERR, p, st);
      chk("R8 parity error pulses", p, 1);
      chk("R8 parity bit 1", st, 8'h02);
      clear_all();
   endtask

   task automatic t_simultaneous();
      logic p; logic [7:0] st; logic [7:0] d;
      apply((9'(1) << S_MABT) | (9'(1) << S_PERR), p, st);
      chk("R11 joint events one pulse", p, 1);
      chk("R11 joint events both bits", st, 8'h12);
      apply('0, p, st);
      chk("R11 joint pulse one cycle", p, 0);
      cfg_read(A_STAT, d);
      chk("R13 status readable at 0x65", d, 8'h12);
      cfg_write(A_STAT, 8'h10);
      chk("R13 partial W1C keeps other bit", err_status, 8'h02);
   endtask

   task automatic t_set_wins();
      @(negedge clk);
      cfg_addr = A_STAT; cfg_wdata = 8'h02; cfg_wr = 1'b1;
      stim = 9'(1) << S_PERR;
      @(negedge clk);
      cfg_wr = 1'b0; stim = '0;
      chk("R13 new event beats clear", err_status, 8'h02);
      chk("R11 pulse with clear in same cycle", serr_req, 1);
      clear_all();
      chk("R13 cleared afterwards", err_status, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask_rw();
      t_dr_timeout();
      t_dw_timeout();
      t_pw_timeout();
      t_restart();
      t_aborts();
      t_parity();
      t_simultaneous();
      t_set_wins();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule